// File: doc/BRIEF.md
# Edge-Interrupt GPIO Port

This block is a 32-line general-purpose I/O port with a word-addressed register interface. Software picks a direction per line, may turn any output into an open-drain driver, writes an output latch, and reads back a data word that merges the output latch for driven lines with the synchronised pad level for input lines. Input levels only reach the data word for lines whose input buffer has been switched on.

Every pad input passes through a two-flop synchroniser. A falling edge, or either edge, depending on a per-line edge-control bit, latches a sticky event bit. Software clears events by writing ones. A single interrupt output is raised whenever any pending event meets a set mask bit. Line n always sits at register bit 31-n, while the pad vectors are indexed by line number.

Top module: `gpio_edge_port`

## Requirements
- R1: After reset every register reads 0, `pad_oe` is all zeros and `irq` is low.
- R2: Word index selects the register: 0 direction, 1 open-drain, 2 data, 3 event, 4 mask, 5 edge control, 6 input enable. Index 7 reads 0 and a write there changes nothing. Line n is register bit 31-n. `rdata` is loaded at the clock edge where `rd_en` is high.
- R3: A direction bit of 1 makes the line an output. With its open-drain bit 0 the pad is driven (`pad_oe`=1) with the output latch value.
- R4: An output line with open-drain bit 1 drives `pad_out`=0 with `pad_oe`=1 for latch 0 and releases (`pad_oe`=0) for latch 1.
- R5: For an input line the data bit reads the pad level two clocks after it changes when the input enable bit is 1, and reads 0 when it is 0.
- R6: For an output line the data bit reads the output latch, whatever the pad level.
- R7: Edge control 0 latches an event on both pad edges; edge control 1 latches only on a falling edge. An event bit is set on the third clock edge after the pad change.
- R8: Writing 1 to an event bit clears it; writing 0 leaves it unchanged; a write never sets an event.
- R9: `irq` is high exactly when some event bit and the same mask bit are both 1.
- R10: If a new edge and a clearing write hit the same event bit in one cycle, the bit stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 3 | Register word index |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| pad_in | input | 32 | Pad input levels, index = line |
| pad_out | output | 32 | Pad output values, index = line |
| pad_oe | output | 32 | Pad output enables, index = line |
| irq | output | 1 | Combined interrupt |

## Verification
The event latch and the write-one-to-clear path can act on the same event bit in one cycle. The bench arms a pending event on one line, then times a pad toggle on another line so its edge reaches the event register on exactly the clock edge at which an all-ones clear is written. The read-back must show the old event gone and the new one kept, and a checker property requires every detected falling edge to appear in the event word on the following cycle.

// File: rtl/gpx_pkg.sv
package gpx_pkg;

    localparam int LINES = 32;
    localparam int IDX_W = 3;

    typedef logic [LINES-1:0] word_t;

    typedef enum logic [IDX_W-1:0] {
        IDX_DIR  = 3'd0,
        IDX_ODR  = 3'd1,
        IDX_DATA = 3'd2,
        IDX_EVT  = 3'd3,
        IDX_MASK = 3'd4,
        IDX_ECTL = 3'd5,
        IDX_IBE  = 3'd6
    } reg_idx_e;

    typedef struct packed {
        word_t dir;
        word_t odr;
        word_t dout;
        word_t ibe;
        word_t mask;
        word_t ectl;
    } port_cfg_t;

    // Register bit 31-n belongs to pad line n.
    function automatic word_t flip(input word_t v);
        word_t r;
        for (int i = 0; i < LINES; i++) begin
            r[i] = v[LINES-1-i];
        end
        return r;
    endfunction

endpackage

// File: rtl/gpx_sync_bank.sv
module gpx_sync_bank #(
    parameter int W      = 32,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] din,
    output logic [W-1:0] sync_q,
    output logic [W-1:0] prev_q
);
    logic [W-1:0] stg [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) stg[s] <= '0;
                    else     stg[s] <= din;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) stg[s] <= '0;
                    else     stg[s] <= stg[s-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) prev_q <= '0;
        else     prev_q <= stg[STAGES-1];
    end

    assign sync_q = stg[STAGES-1];
endmodule

// File: rtl/gpx_event_unit.sv
module gpx_event_unit #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] sync_q,
    input  logic [W-1:0] prev_q,
    input  logic [W-1:0] fall_only,
    input  logic [W-1:0] clr,
    output logic [W-1:0] evt_q
);
    logic [W-1:0] fall, rise, hit, evt_d;

    always_comb begin
        fall  = prev_q & ~sync_q;
        rise  = ~prev_q & sync_q;
        hit   = fall | (rise & ~fall_only);
        // a fresh edge outranks a same-cycle clear
        evt_d = (evt_q & ~clr) | hit;
    end

    always_ff @(posedge clk) begin
        if (rst) evt_q <= '0;
        else     evt_q <= evt_d;
    end
endmodule

// File: rtl/gpx_pad_drive.sv
module gpx_pad_drive #(
    parameter int W = 32
) (
    input  logic [W-1:0] dir,
    input  logic [W-1:0] odr,
    input  logic [W-1:0] dout,
    output logic [W-1:0] oe,
    output logic [W-1:0] val
);
    generate
        for (genvar i = 0; i < W; i++) begin : g_bit
            always_comb begin
                if (odr[i]) begin
                    oe[i]  = dir[i] & ~dout[i];
                    val[i] = 1'b0;
                end else begin
                    oe[i]  = dir[i];
                    val[i] = dir[i] & dout[i];
                end
            end
        end
    endgenerate
endmodule

// File: rtl/gpio_edge_port.sv
module gpio_edge_port import gpx_pkg::*; #(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic             rd_en,
    input  logic [IDX_W-1:0] addr,
    input  logic [LINES-1:0] wdata,
    output logic [LINES-1:0] rdata,
    input  logic [LINES-1:0] pad_in,
    output logic [LINES-1:0] pad_out,
    output logic [LINES-1:0] pad_oe,
    output logic             irq
);
    port_cfg_t cfg_q;
    word_t     sync_q, prev_q, evt_q, evt_clr, data_view, rd_mux;
    word_t     oe_r, val_r;

    gpx_sync_bank #(.W(LINES), .STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst    (rst),
        .din    (flip(pad_in)),
        .sync_q (sync_q),
        .prev_q (prev_q)
    );

    assign evt_clr = (wr_en && addr == IDX_EVT) ? wdata : '0;

    gpx_event_unit #(.W(LINES)) u_evt (
        .clk       (clk),
        .rst       (rst),
        .sync_q    (sync_q),
        .prev_q    (prev_q),
        .fall_only (cfg_q.ectl),
        .clr       (evt_clr),
        .evt_q     (evt_q)
    );

    gpx_pad_drive #(.W(LINES)) u_pad (
        .dir  (cfg_q.dir),
        .odr  (cfg_q.odr),
        .dout (cfg_q.dout),
        .oe   (oe_r),
        .val  (val_r)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
        end else if (wr_en) begin
            case (addr)
                IDX_DIR:  cfg_q.dir  <= wdata;
                IDX_ODR:  cfg_q.odr  <= wdata;
                IDX_DATA: cfg_q.dout <= wdata;
                IDX_MASK: cfg_q.mask <= wdata;
                IDX_ECTL: cfg_q.ectl <= wdata;
                IDX_IBE:  cfg_q.ibe  <= wdata;
                default:  ;
            endcase
        end
    end

    always_comb begin
        data_view = (cfg_q.dir & cfg_q.dout) | (~cfg_q.dir & cfg_q.ibe & sync_q);
        case (addr)
            IDX_DIR:  rd_mux = cfg_q.dir;
            IDX_ODR:  rd_mux = cfg_q.odr;
            IDX_DATA: rd_mux = data_view;
            IDX_EVT:  rd_mux = evt_q;
            IDX_MASK: rd_mux = cfg_q.mask;
            IDX_ECTL: rd_mux = cfg_q.ectl;
            IDX_IBE:  rd_mux = cfg_q.ibe;
            default:  rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)        rdata <= '0;
        else if (rd_en) rdata <= rd_mux;
    end

    assign pad_oe  = flip(oe_r);
    assign pad_out = flip(val_r);
    assign irq     = |(evt_q & cfg_q.mask);
endmodule

// File: rtl/gpx_port_checker.sv
module gpx_port_checker import gpx_pkg::*; (
    input logic             clk,
    input logic             rst,
    input logic             wr_en,
    input logic [IDX_W-1:0] addr,
    input logic [LINES-1:0] pad_oe,
    input logic [LINES-1:0] pad_out,
    input logic             irq,
    input logic [LINES-1:0] odr_q,
    input logic [LINES-1:0] mask_q,
    input logic [LINES-1:0] evt_q,
    input logic [LINES-1:0] sync_q,
    input logic [LINES-1:0] prev_q
);
    AST_RESET_QUIET: assert property (@(posedge clk)
        rst |=> (pad_oe == '0 && !irq)); // R1

    AST_OD_NEVER_HIGH: assert property (@(posedge clk) disable iff (rst)
        (pad_oe & pad_out & flip(odr_q)) == '0); // R4

    AST_MASKED_SILENT: assert property (@(posedge clk) disable iff (rst)
        (mask_q == '0) |-> !irq); // R9

    AST_EVT_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!(wr_en && addr == IDX_EVT) && sync_q == prev_q) |=> $stable(evt_q)); // R8

    AST_FALL_LATCHED: assert property (@(posedge clk) disable iff (rst)
        (|(prev_q & ~sync_q)) |=>
        ((evt_q & $past(prev_q & ~sync_q)) == $past(prev_q & ~sync_q))); // R10
endmodule

bind gpio_edge_port gpx_port_checker u_chk (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .addr    (addr),
    .pad_oe  (pad_oe),
    .pad_out (pad_out),
    .irq     (irq),
    .odr_q   (cfg_q.odr),
    .mask_q  (cfg_q.mask),
    .evt_q   (evt_q),
    .sync_q  (sync_q),
    .prev_q  (prev_q)
);

// File: tb/test_gpio_edge_port.sv
module test_gpio_edge_port;
    localparam int CLK_PERIOD = 10;

    logic        clk = 0;
    logic        rst = 1;
    logic        wr_en = 0, rd_en = 0;
    logic [2:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata, pad_out, pad_oe;
    logic [31:0] pad_in = '0;
    logic        irq;

    int n_run = 0, n_fail = 0;
    logic rd_pend = 0;

    typedef struct {
        logic [31:0] exp;
        string       tag;
    } sb_item_t;
    sb_item_t sb_q[$];
    sb_item_t it;

    always #(CLK_PERIOD/2) clk = ~clk;

    gpio_edge_port i_gpio_edge_port (
        .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .pad_in(pad_in), .pad_out(pad_out),
        .pad_oe(pad_oe), .irq(irq)
    );

    function automatic void judge(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
        end
    endfunction

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    endtask

    // monitor: compares registered read data against the scoreboard
    always @(posedge clk) rd_pend <= rd_en;
    always @(negedge clk) begin
        if (rd_pend) begin
            if (sb_q.size() == 0) begin
                judge(0, "R2 unexpected read", rdata, '0);
            end else begin
                it = sb_q.pop_front();
                judge(rdata === it.exp, it.tag, rdata, it.exp);
            end
        end
    end

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 0;
    endtask

    task automatic rd(input logic [2:0] a, input logic [31:0] e, input string tag);
        sb_item_t x;
        @(negedge clk);
        x.exp = e; x.tag = tag;
        sb_q.push_back(x);
        rd_en = 1; addr = a;
        @(negedge clk);
        rd_en = 0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (CLK_PERIOD * 2000) @(posedge clk);
        judge(0, "watchdog expired", '0, '0);
        summary();
    end

    initial begin
        idle(3);
        rst = 0;
        // R1 reset state
        judge(pad_oe === '0, "R1 pad_oe after reset", pad_oe, '0);
        judge(irq === 1'b0, "R1 irq after reset", {31'b0, irq}, '0);
        for (int i = 0; i < 8; i++) rd(3'(i), '0, "R1 register reset value");

        // R3 push-pull outputs on lines 0..3, latch ones on lines 0 and 2
        wr(3'd0, 32'hF000_0000);
        wr(3'd2, 32'hA000_0000);
        judge(pad_oe === 32'h0000_000F, "R3 pad_oe", pad_oe, 32'h0000_000F);
        judge(pad_out === 32'h0000_0005, "R3 pad_out", pad_out, 32'h0000_0005);
        rd(3'd2, 32'hA000_0000, "R6 data reads output latch");

        // R2 index 7 is empty and ignores writes
        wr(3'd7, 32'hFFFF_FFFF);
        rd(3'd7, '0, "R2 index 7 reads 0");
        rd(3'd0, 32'hF000_0000, "R2 direction unchanged by index 7 write");

        // R4 open-drain on lines 0 and 1
        wr(3'd1, 32'hC000_0000);
        judge(pad_oe === 32'h0000_000E, "R4 pad_oe open-drain", pad_oe, 32'h0000_000E);
        judge(pad_out === 32'h0000_0004, "R4 pad_out open-drain", pad_out, 32'h0000_0004);

        // R5 input enable on line 8 only; lines 8 and 9 rise
        wr(3'd6, 32'h0080_0000);
        @(negedge clk);
        pad_in[8] = 1; pad_in[9] = 1;
        idle(4);
        rd(3'd2, 32'hA080_0000, "R5 enabled input visible, R6 outputs keep latch");
        wr(3'd6, 32'h0000_0000);
        rd(3'd2, 32'hA000_0000, "R5 disabled input reads 0");

        // R7 both-edge default latched rising edges on lines 8, 9
        rd(3'd3, 32'h00C0_0000, "R7 rising edges latched");
        judge(irq === 1'b0, "R9 irq low with mask clear", {31'b0, irq}, '0);
        wr(3'd4, 32'h0080_0000);
        judge(irq === 1'b1, "R9 irq high on masked event", {31'b0, irq}, 32'h1);
        wr(3'd3, 32'h0000_0000);
        rd(3'd3, 32'h00C0_0000, "R8 writing zeros keeps events");
        wr(3'd3, 32'h0080_0000);
        rd(3'd3, 32'h0040_0000, "R8 write one clears that bit only");
        judge(irq === 1'b0, "R9 irq low after clear", {31'b0, irq}, '0);
        wr(3'd3, 32'hFFFF_FFFF);
        rd(3'd3, 32'h0000_0000, "R8 clear all");

        // R7 falling-only on line 10
        wr(3'd5, 32'h0020_0000);
        @(negedge clk); pad_in[10] = 1; idle(4);
        rd(3'd3, 32'h0000_0000, "R7 falling-only ignores rise");
        @(negedge clk); pad_in[10] = 0; idle(4);
        rd(3'd3, 32'h0020_0000, "R7 falling-only latches fall");
        // line 11 both edges
        @(negedge clk); pad_in[11] = 1; idle(4);
        rd(3'd3, 32'h0030_0000, "R7 both-edge rise");
        wr(3'd3, 32'h0010_0000);
        @(negedge clk); pad_in[11] = 0; idle(4);
        rd(3'd3, 32'h0030_0000, "R7 both-edge fall");
        wr(3'd3, 32'h0010_0000);
        rd(3'd3, 32'h0020_0000, "R8 selective clear");

        // R10 edge on line 12 collides with a clear-all write
        @(negedge clk); pad_in[12] = 1;
        @(negedge clk);
        @(negedge clk);
        wr_en = 1; addr = 3'd3; wdata = 32'hFFFF_FFFF;
        @(negedge clk);
        wr_en = 0;
        rd(3'd3, 32'h0008_0000, "R10 new edge survives clear");

        idle(3);
        judge(sb_q.size() == 0, "R2 scoreboard drained", 32'(sb_q.size()), '0);
        summary();
    end
endmodule